// File: doc/BRIEF.md
# PS/2 Keyboard Scan Code Reader

This block turns the two open-collector lines of a PS/2 keyboard, a slow clock and a data line that both rest high, into an 8-bit parallel scan code and a busy flag. It runs on a fast system clock. The keyboard clock is treated as an asynchronous signal: both lines go through a short synchronizer, and every bit is taken on the synchronized high-to-low transition of the keyboard clock.

A press and release of one key arrives as three back-to-back 11-bit frames. The first carries the make code, the second the break prefix, and the third repeats the key's code. The reader does not decode frames one at a time. It counts 33 keyboard clock falls as one reception and then presents the data byte of the last frame. Each frame is a start bit (0), eight data bits least significant first, a parity bit and a stop bit (1). Parity is not checked. Inside, a datapath holds an 11-bit shift register, a bit counter and the output register. A small control state machine drives them with shift, clear, increment and load strobes, and reads back a count-done status.

Top module: `ps2_scan_reader`

## Requirements
- R1: While `rst` is high on a clock edge, the reader goes idle: `busy` is 0, `scan_code` is 0 and the bit counter is cleared.
- R2: While the keyboard clock stays high, the reader stays idle with `busy` low, whatever `kb_data` does, and `scan_code` does not change.
- R3: `busy` goes high within a few system clocks of the first keyboard clock fall of a reception.
- R4: `busy` stays high through the first 32 keyboard clock falls of a reception. It goes low only after the 33rd fall.
- R5: When a reception ends, `scan_code` holds the eight data bits of the third frame. Frame bit 1 is `scan_code[0]` and frame bit 8 is `scan_code[7]`, where frame bit 0 is the first bit sent (start).
- R6: `scan_code` keeps its value from the end of one reception until the end of the next. It does not change while `busy` is high.
- R7: `kb_data` matters only at keyboard clock falls. Changes while the keyboard clock is high do not alter the received code.
- R8: A reset in the middle of a reception discards the partial bits. The next full reception of 33 falls decodes correctly.
- R9: `busy` low means that `scan_code` is valid. `busy` falls in the same cycle in which the new code appears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| kb_clk | input | 1 | Keyboard clock line, asynchronous, idles high |
| kb_data | input | 1 | Keyboard data line, idles high |
| scan_code | output | 8 | Data byte of the last frame of the last complete reception |
| busy | output | 1 | High from the first bit until the code is loaded |

## Verification
The end of a reception and the output update fall on the same clock edge. `busy` drops in the cycle in which `scan_code` takes its new value, so a check that samples too early or too late would see a stale code or a stale flag. The bench polls every system clock during the low phase of the last keyboard bit. At the first sample with `busy` low, it compares `scan_code` to the expected byte. A checker also requires that the code changes only when `busy` falls, and that exactly 33 synchronized falls come before that drop.

// File: rtl/ps2_scan_reader.sv
module ps2_scan_reader #(
  parameter int FRAME_BITS  = 11,
  parameter int FRAME_COUNT = 3,
  parameter int SYNC_STAGES = 2,
  parameter int CODE_W      = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              kb_clk,
  input  logic              kb_data,
  output logic [CODE_W-1:0] scan_code,
  output logic              busy
);
  localparam int TOTAL = FRAME_BITS * FRAME_COUNT;
  localparam int CNT_W = $clog2(TOTAL + 1);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(TOTAL - 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_WAIT_RISE, ST_WAIT_FALL, ST_LOAD, ST_WAIT_END
  } state_t;

  logic [SYNC_STAGES-1:0] clk_sync, dat_sync;
  logic                   kclk_prev;
  logic                   kclk_s, kdat_s, kfall;

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_sync  <= '1;
      dat_sync  <= '1;
      kclk_prev <= 1'b1;
    end else begin
      clk_sync  <= {clk_sync[SYNC_STAGES-2:0], kb_clk};
      dat_sync  <= {dat_sync[SYNC_STAGES-2:0], kb_data};
      kclk_prev <= kclk_s;
    end
  end

  assign kclk_s = clk_sync[SYNC_STAGES-1];
  assign kdat_s = dat_sync[SYNC_STAGES-1];
  assign kfall  = kclk_prev & ~kclk_s;

  logic                  shift_en, cnt_clr, cnt_inc, load_out, cnt_done;
  logic [FRAME_BITS-1:0] shift_reg;
  logic [CNT_W-1:0]      bit_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      shift_reg <= '1;
      bit_cnt   <= '0;
      scan_code <= '0;
    end else begin
      if (shift_en) shift_reg <= {kdat_s, shift_reg[FRAME_BITS-1:1]};
      if (cnt_clr)      bit_cnt <= '0;
      else if (cnt_inc) bit_cnt <= bit_cnt + 1'b1;
      if (load_out) scan_code <= shift_reg[CODE_W:1];
    end
  end

  assign cnt_done = (bit_cnt == LAST_IDX);

  state_t state, state_nx;

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= state_nx;
  end

  always_comb begin
    state_nx = state;
    shift_en = 1'b0;
    cnt_clr  = 1'b0;
    cnt_inc  = 1'b0;
    load_out = 1'b0;
    case (state)
      ST_IDLE, ST_WAIT_FALL:
        if (kfall) begin
          shift_en = 1'b1;
          if (cnt_done) begin
            cnt_clr  = 1'b1;
            state_nx = ST_LOAD;
          end else begin
            cnt_inc  = 1'b1;
            state_nx = ST_WAIT_RISE;
          end
        end
      ST_WAIT_RISE: if (kclk_s) state_nx = ST_WAIT_FALL;
      ST_LOAD: begin
        load_out = 1'b1;
        state_nx = ST_WAIT_END;
      end
      ST_WAIT_END: if (kclk_s) state_nx = ST_IDLE;
      default: state_nx = ST_IDLE;
    endcase
  end

  assign busy = (state == ST_WAIT_RISE) || (state == ST_WAIT_FALL) || (state == ST_LOAD);
endmodule

module ps2_scan_reader_chk #(
  parameter int TOTAL  = 33,
  parameter int CODE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              kclk_s,
  input logic [CODE_W-1:0] scan_code
);
  localparam int FW = $clog2(TOTAL + 2);
  logic [FW-1:0] fall_cnt;
  logic          busy_q, kclk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      fall_cnt <= '0;
      busy_q   <= 1'b0;
      kclk_q   <= 1'b1;
    end else begin
      busy_q <= busy;
      kclk_q <= kclk_s;
      if (busy_q && !busy)      fall_cnt <= '0;
      else if (kclk_q && !kclk_s) fall_cnt <= fall_cnt + 1'b1;
    end
  end

  p_reset_idle_r1: assert property (@(posedge clk) rst |=> (!busy && scan_code == '0));
  p_idle_holds_r2: assert property (@(posedge clk) disable iff (rst)
    (!busy && kclk_s) |=> !busy);
  p_end_after_all_falls_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (fall_cnt == FW'(TOTAL)));
  p_code_moves_at_end_r6: assert property (@(posedge clk) disable iff (rst)
    !$stable(scan_code) |-> $fell(busy));
endmodule

bind ps2_scan_reader ps2_scan_reader_chk #(
  .TOTAL(FRAME_BITS * FRAME_COUNT), .CODE_W(CODE_W)
) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .kclk_s(kclk_s), .scan_code(scan_code)
);

// File: tb/ps2_scan_reader_tb.sv
module ps2_scan_reader_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       kb_clk = 1'b1;
  logic       kb_data = 1'b1;
  logic [7:0] scan_code;
  logic       busy;
  int checks = 0;
  int errors = 0;
  logic [7:0] last_code = 8'h00;

  always #5 clk = ~clk;

  ps2_scan_reader u_dut (
    .clk(clk), .rst(rst), .kb_clk(kb_clk), .kb_data(kb_data),
    .scan_code(scan_code), .busy(busy)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [10:0] frame(input logic [7:0] b);
    return {1'b1, ~^b, b, 1'b0};
  endfunction

  task automatic send_bit(input logic v, input bit wiggle);
    kb_data = v;
    wait_cyc(10);
    kb_clk = 1'b0;
    wait_cyc(20);
    kb_clk = 1'b1;
    if (wiggle) begin
      wait_cyc(3); kb_data = ~v;
      wait_cyc(3); kb_data = v;
      wait_cyc(2); kb_data = ~v;
      wait_cyc(2);
    end else wait_cyc(10);
  endtask

  task automatic reception(input logic [7:0] b0, input logic [7:0] b1,
                           input logic [7:0] b2, input bit wiggle, input string tag);
    logic [32:0] seq;
    seq = {frame(b2), frame(b1), frame(b0)};
    for (int i = 0; i < 32; i++) begin
      send_bit(seq[i], wiggle);
      if (i == 0) check({"R3 busy after first fall ", tag}, busy, 1);
      if (i == 31) begin
        check({"R4 busy after 32 falls ", tag}, busy, 1);
        check({"R6 code held while busy ", tag}, scan_code, last_code);
      end
    end
    kb_data = seq[32];
    wait_cyc(10);
    kb_clk = 1'b0;
    for (int c = 0; c < 20 && busy; c++) begin
      if (scan_code !== last_code)
        check({"R9 code changed before busy fell ", tag}, scan_code, last_code);
      wait_cyc(1);
    end
    check({"R4 busy low after 33 falls ", tag}, busy, 0);
    check({"R5 R9 code at busy fall ", tag}, scan_code, b2);
    wait_cyc(20);
    kb_clk = 1'b1;
    kb_data = 1'b1;
    wait_cyc(10);
    check({"R6 code kept after end ", tag}, scan_code, b2);
    last_code = b2;
  endtask

  task automatic t_reset;
    rst = 1'b1;
    wait_cyc(4);
    rst = 1'b0;
    wait_cyc(2);
    check("R1 busy after reset", busy, 0);
    check("R1 code after reset", scan_code, 0);
  endtask

  task automatic t_idle_data;
    for (int i = 0; i < 6; i++) begin
      kb_data = i[0];
      wait_cyc(7);
    end
    kb_data = 1'b1;
    wait_cyc(5);
    check("R2 busy idle with data toggling", busy, 0);
    check("R2 code idle with data toggling", scan_code, last_code);
  endtask

  task automatic t_press_patterns;
    reception(8'h1C, 8'hF0, 8'h1C, 1'b0, "a");
    reception(8'h5A, 8'hF0, 8'h5A, 1'b0, "b");
    reception(8'hFF, 8'hF0, 8'h81, 1'b0, "c");
    reception(8'h00, 8'hF0, 8'h00, 1'b0, "d");
  endtask

  task automatic t_wiggle;
    reception(8'h3C, 8'hF0, 8'h3C, 1'b1, "R7 wiggle");
    t_idle_data();
  endtask

  task automatic t_reset_mid;
    logic [10:0] f;
    f = frame(8'h29);
    for (int i = 0; i < 11; i++) send_bit(f[i], 1'b0);
    send_bit(1'b0, 1'b0);
    check("R8 busy mid reception", busy, 1);
    rst = 1'b1;
    wait_cyc(4);
    rst = 1'b0;
    wait_cyc(2);
    check("R8 busy after mid reset", busy, 0);
    check("R8 code after mid reset", scan_code, 0);
    last_code = 8'h00;
    reception(8'h29, 8'hF0, 8'h29, 1'b0, "R8 after reset");
  endtask

  initial begin
    t_reset();
    t_idle_data();
    t_press_patterns();
    t_wiggle();
    t_reset_mid();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1_900_000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule